// File: doc/BRIEF.md
# Receive Word FIFO with Programmable Level Flags

This block buffers 32-bit words arriving from a parallel digital input port until a host-side reader, typically a DMA engine, drains them through one fixed-address data register. Words from the input side are stored only while the receive-enable control bit is set. Every read of the data register removes the oldest word. The FIFO depth is a parameter.

Software controls and watches the FIFO through a small word-addressed register bus. One register holds two programmable thresholds that define the almost-empty and almost-full levels. A status register reports the fill state as four flags of inverted sense ("not empty", "not almost full" and so on). It also holds two sticky error bits: one for a word that arrived while the FIFO was full, and one for a read taken from an empty FIFO. Software clears each error bit by writing a one to its position. Two more registers give the capacity and the current fill level. A flush control empties the FIFO. A whole-block reset control returns every setting to its reset value and then refuses FIFO traffic for a fixed settle window.

Register map (word address on `reg_addr`): 0 control, 1 status, 2 thresholds, 3 data (a read pops), 4 capacity, 5 level. Addresses 6 and 7 read as zero.

Top module: `rx_word_fifo`

## Requirements
- R1: After `rst`, control reads 0, level reads 0, thresholds read 0x0020_0020 (both counts 32), capacity reads DEPTH, status reads 0x0000_C000, and addresses 6 and 7 read 0.
- R2: An input word (`in_valid` high) is stored only while control bit 5 (receive enable) is 1. Reads of address 3 return the stored words oldest first, and each such read removes one word.
- R3: Status bit 12 is 1 exactly when the level is non-zero. Status bit 15 is 1 exactly when the level is below DEPTH. Both flags reflect a push or pop in the cycle after the clock edge that performs it.
- R4: The threshold register holds the almost-empty count in bits 15:0 and the almost-full count in bits 31:16. Status bit 13 is 1 when level > almost-empty count. Status bit 14 is 1 when level + almost-full count < DEPTH.
- R5: An input word that arrives while the FIFO is full, with no pop in the same cycle, is discarded and sets status bit 23 (overrun). The bit stays set until it is cleared, and the stored words are unchanged.
- R6: A read of address 3 while the FIFO is empty leaves the level at 0 and sets status bit 22 (underrun). The bit stays set until it is cleared.
- R7: Writing status with bit 23 or bit 22 set clears that error bit only. A bit written as 0 leaves its error bit unchanged.
- R8: Writing control with bit 2 set empties the FIFO. Bit 2 reads back as 0, and the error bits are not affected.
- R9: A push and a pop in the same cycle leave the level unchanged. This holds when the FIFO is full: the incoming word is then stored and no overrun is flagged. Word order is preserved.
- R10: Writing control with bit 0 set empties the FIFO, restores the R1 register values, and for SETTLE_CYC cycles afterwards ignores input words and data reads (no level change, no underrun). After that window, words are accepted again.
- R11: Capacity (address 4) and level (address 5) are 20-bit values in bits 19:0, with zeros above.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input word present this cycle |
| in_data | input | 32 | Input word |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops when address is 3) |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from `reg_addr` |

## Verification
The fill path is driven with distinct word patterns so that a lost, duplicated or reordered word shows up when the data is read back. Words are also offered with the enable bit off, to tell gating apart from storage. The FIFO is stepped one word at a time across asymmetric thresholds (2 and 3), so that each inverted flag is seen to change at its exact level and an off-by-one in either comparison is exposed. Overflow, empty reads, a simultaneous push and pop at full, flush and the block reset with its settle window each have a separate scenario. In these scenarios the sticky bits, the write-one-to-clear behaviour and the blocking of traffic can be told apart from an ordinary flush.

// File: rtl/rxf_pkg.sv
package rxf_pkg;

    localparam int DATA_W  = 32;
    localparam int REG_AW  = 3;
    localparam int THR_W   = 16;
    localparam int FIELD_W = 20;

    // control bit positions
    localparam int CB_BRST  = 0;
    localparam int CB_FLUSH = 2;
    localparam int CB_EN    = 5;
    // status bit positions
    localparam int SB_LVL_LO = 12;
    localparam int SB_UND    = 22;
    localparam int SB_OVR    = 23;

    typedef enum logic [REG_AW-1:0] {
        A_CTRL  = 3'd0,
        A_STAT  = 3'd1,
        A_THR   = 3'd2,
        A_DATA  = 3'd3,
        A_CAP   = 3'd4,
        A_LEVEL = 3'd5
    } rxf_addr_e;

    // packed order maps directly onto status bits 15..12
    typedef struct packed {
        logic not_full;
        logic not_afull;
        logic not_aempty;
        logic not_empty;
    } rxf_lvl_t;

    typedef struct packed {
        logic ovr;
        logic und;
    } rxf_err_t;

    typedef struct packed {
        logic [THR_W-1:0] af;
        logic [THR_W-1:0] ae;
    } rxf_thr_t;

    function automatic logic [DATA_W-1:0] pack_status(rxf_lvl_t l, rxf_err_t e);
        logic [DATA_W-1:0] s;
        s = '0;
        s[SB_LVL_LO +: 4] = l;
        s[SB_OVR] = e.ovr;
        s[SB_UND] = e.und;
        return s;
    endfunction

    function automatic logic [DATA_W-1:0] field20(int unsigned v);
        logic [DATA_W-1:0] r;
        r = '0;
        r[FIELD_W-1:0] = FIELD_W'(v);
        return r;
    endfunction

endpackage

// File: rtl/rxf_store.sv
module rxf_store
    import rxf_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int AW = $clog2(DEPTH),
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              push_req,
    input  logic              pop_req,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] head,
    output logic [CW-1:0]     count,
    output logic              ovr_evt,
    output logic              und_evt
);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [AW-1:0]     wptr, rptr;
    logic              is_full, is_empty, pop_ok, push_ok;

    assign is_full  = (count == CW'(DEPTH));
    assign is_empty = (count == '0);
    assign pop_ok   = pop_req && !is_empty;
    assign push_ok  = push_req && (!is_full || pop_ok);
    assign ovr_evt  = push_req && !push_ok && !clear;
    assign und_evt  = pop_req && is_empty && !clear;
    assign head     = mem[rptr];

    always_ff @(posedge clk) begin
        if (push_ok && !clear) begin
            mem[wptr] <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (push_ok) wptr <= wptr + 1'b1;
            if (pop_ok)  rptr <= rptr + 1'b1;
            case ({push_ok, pop_ok})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    // R5
    full_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (is_full && push_req && !pop_req && !clear) |=> (count == CW'(DEPTH)));

    // R9
    pair_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (push_req && pop_req && !is_empty && !clear) |=> $stable(count));

    // R6
    empty_pop_chk: assert property (@(posedge clk) disable iff (rst)
        (is_empty && pop_req && !push_req && !clear) |=> (count == '0));

endmodule

// File: rtl/rxf_flags.sv
module rxf_flags
    import rxf_pkg::*;
#(
    parameter int DEPTH = 64,
    localparam int CW = $clog2(DEPTH + 1),
    localparam int EW = THR_W + 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CW-1:0]    count,
    input  logic [THR_W-1:0] ae_thr,
    input  logic [THR_W-1:0] af_thr,
    output rxf_lvl_t         lvl
);

    logic [EW-1:0] cnt_x;

    assign cnt_x = EW'(count);

    always_comb begin
        lvl.not_empty  = (count != '0);
        lvl.not_full   = (count != CW'(DEPTH));
        lvl.not_aempty = (cnt_x > EW'(ae_thr));
        lvl.not_afull  = ((cnt_x + EW'(af_thr)) < EW'(DEPTH));
    end

    // R4
    lvl_order_chk: assert property (@(posedge clk) disable iff (rst)
        !lvl.not_empty |-> !lvl.not_aempty);

    // R4
    full_afull_chk: assert property (@(posedge clk) disable iff (rst)
        !lvl.not_full |-> !lvl.not_afull);

endmodule

// File: rtl/rxf_ctrl.sv
module rxf_ctrl
    import rxf_pkg::*;
#(
    parameter int SETTLE_CYC = 500,
    parameter int AE_RST     = 32,
    parameter int AF_RST     = 32,
    localparam int SW = $clog2(SETTLE_CYC + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic              in_valid,
    input  logic              ovr_evt,
    input  logic              und_evt,
    output logic              rx_en,
    output rxf_thr_t          thr,
    output rxf_err_t          err,
    output logic              busy,
    output logic              clear,
    output logic              push_req,
    output logic              pop_req
);

    logic [SW-1:0] settle;
    logic wr_ctrl, wr_stat, wr_thr, brst_wr, flush_wr;

    assign wr_ctrl  = reg_wr && (reg_addr == A_CTRL);
    assign wr_stat  = reg_wr && (reg_addr == A_STAT);
    assign wr_thr   = reg_wr && (reg_addr == A_THR);
    assign brst_wr  = wr_ctrl && reg_wdata[CB_BRST];
    assign flush_wr = wr_ctrl && reg_wdata[CB_FLUSH];

    assign busy     = (settle != '0);
    assign clear    = brst_wr || flush_wr;
    assign push_req = in_valid && rx_en && !busy;
    assign pop_req  = reg_rd && (reg_addr == A_DATA) && !busy;

    always_ff @(posedge clk) begin
        if (rst || brst_wr) begin
            rx_en  <= 1'b0;
            thr.ae <= THR_W'(AE_RST);
            thr.af <= THR_W'(AF_RST);
            err    <= '0;
            settle <= rst ? '0 : SW'(SETTLE_CYC);
        end else begin
            if (wr_ctrl) rx_en <= reg_wdata[CB_EN];
            if (wr_thr)  thr   <= reg_wdata;
            err.ovr <= (err.ovr && !(wr_stat && reg_wdata[SB_OVR])) || ovr_evt;
            err.und <= (err.und && !(wr_stat && reg_wdata[SB_UND])) || und_evt;
            if (busy) settle <= settle - 1'b1;
        end
    end

    // R5
    ovr_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (err.ovr && !brst_wr && !(wr_stat && reg_wdata[SB_OVR])) |=> err.ovr);

    // R6
    und_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (err.und && !brst_wr && !(wr_stat && reg_wdata[SB_UND])) |=> err.und);

endmodule

// File: rtl/rx_word_fifo.sv
module rx_word_fifo
    import rxf_pkg::*;
#(
    parameter int DEPTH      = 64,
    parameter int SETTLE_CYC = 500,
    parameter int AE_RST     = 32,
    parameter int AF_RST     = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata
);

    localparam int CW = $clog2(DEPTH + 1);

    logic              rx_en, busy, clear, push_req, pop_req, ovr_evt, und_evt;
    rxf_thr_t          thr;
    rxf_err_t          err;
    rxf_lvl_t          lvl;
    logic [CW-1:0]     count;
    logic [DATA_W-1:0] head;

    rxf_ctrl #(
        .SETTLE_CYC(SETTLE_CYC),
        .AE_RST    (AE_RST),
        .AF_RST    (AF_RST)
    ) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .reg_wr   (reg_wr),
        .reg_rd   (reg_rd),
        .reg_addr (reg_addr),
        .reg_wdata(reg_wdata),
        .in_valid (in_valid),
        .ovr_evt  (ovr_evt),
        .und_evt  (und_evt),
        .rx_en    (rx_en),
        .thr      (thr),
        .err      (err),
        .busy     (busy),
        .clear    (clear),
        .push_req (push_req),
        .pop_req  (pop_req)
    );

    rxf_store #(.DEPTH(DEPTH)) u_store (
        .clk     (clk),
        .rst     (rst),
        .clear   (clear),
        .push_req(push_req),
        .pop_req (pop_req),
        .wdata   (in_data),
        .head    (head),
        .count   (count),
        .ovr_evt (ovr_evt),
        .und_evt (und_evt)
    );

    rxf_flags #(.DEPTH(DEPTH)) u_flags (
        .clk   (clk),
        .rst   (rst),
        .count (count),
        .ae_thr(thr.ae),
        .af_thr(thr.af),
        .lvl   (lvl)
    );

    always_comb begin
        case (rxf_addr_e'(reg_addr))
            A_CTRL:  reg_rdata = DATA_W'(rx_en) << CB_EN;
            A_STAT:  reg_rdata = pack_status(lvl, err);
            A_THR:   reg_rdata = thr;
            A_DATA:  reg_rdata = head;
            A_CAP:   reg_rdata = field20(DEPTH);
            A_LEVEL: reg_rdata = field20(32'(count));
            default: reg_rdata = '0;
        endcase
    end

    // R10
    settle_empty_chk: assert property (@(posedge clk) disable iff (rst)
        busy |-> (count == '0));

endmodule

// File: tb/rx_word_fifo_tb.sv
module rx_word_fifo_tb;

    localparam int DEPTH  = 64;
    localparam int SETTLE = 500;
    localparam logic [2:0] AD_CTRL = 3'd0, AD_STAT = 3'd1, AD_THR = 3'd2,
                           AD_DATA = 3'd3, AD_CAP = 3'd4, AD_LVL = 3'd5;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [31:0] in_data = '0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;
    logic [31:0] exp_q[$];

    always #10 clk = ~clk;

    rx_word_fifo #(.DEPTH(DEPTH), .SETTLE_CYC(SETTLE)) u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
    );

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    task automatic wr(logic [2:0] a, logic [31:0] d);
        @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(posedge clk); #1 reg_wr = 1'b0;
    endtask

    task automatic peek(logic [2:0] a, output logic [31:0] v);
        @(negedge clk); reg_addr = a; #1 v = reg_rdata;
    endtask

    task automatic push(logic [31:0] d);
        @(negedge clk); in_data = d; in_valid = 1'b1;
        @(posedge clk); #1 in_valid = 1'b0;
    endtask

    task automatic pop(output logic [31:0] v);
        @(negedge clk); reg_addr = AD_DATA; reg_rd = 1'b1; #1 v = reg_rdata;
        @(posedge clk); #1 reg_rd = 1'b0;
    endtask

    task automatic push_pop(logic [31:0] d, output logic [31:0] v);
        @(negedge clk); in_data = d; in_valid = 1'b1;
        reg_addr = AD_DATA; reg_rd = 1'b1; #1 v = reg_rdata;
        @(posedge clk); #1 in_valid = 1'b0; reg_rd = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        peek(AD_CTRL, v); check("R1 ctrl", v, 32'h0);
        peek(AD_LVL, v);  check("R1 level", v, 32'h0);
        peek(AD_THR, v);  check("R1 thresholds", v, 32'h0020_0020);
        peek(AD_CAP, v);  check("R1/R11 capacity", v, 32'(DEPTH));
        peek(AD_STAT, v); check("R1 status", v, 32'h0000_C000);
        peek(3'd6, v);    check("R1 addr6", v, 32'h0);
        peek(3'd7, v);    check("R1 addr7", v, 32'h0);
    endtask

    task automatic t_gate_order();
        logic [31:0] v;
        for (int i = 0; i < 3; i++) push(32'hDEAD_0000 + i);
        peek(AD_LVL, v); check("R2 disabled drop", v, 32'h0);
        wr(AD_CTRL, 32'h20);
        peek(AD_CTRL, v); check("R2 enable readback", v, 32'h20);
        for (int i = 0; i < 5; i++) push(32'h1234_5670 ^ (i * 32'h0101_0101));
        peek(AD_LVL, v); check("R2/R11 level 5", v, 32'd5);
        peek(AD_STAT, v); check("R3 nonempty", v & 32'h0000_9000, 32'h0000_9000);
        for (int i = 0; i < 5; i++) begin
            pop(v); check("R2 order", v, 32'h1234_5670 ^ (i * 32'h0101_0101));
        end
        peek(AD_STAT, v); check("R3 empty again", v & 32'h0000_1000, 32'h0);
    endtask

    task automatic t_levels_overrun();
        logic [31:0] v;
        wr(AD_THR, 32'h0003_0002);
        peek(AD_THR, v); check("R4 thr readback", v, 32'h0003_0002);
        peek(AD_STAT, v); check("R4 empty flags", v[15:12], 32'h0000_000C);
        exp_q.delete();
        for (int i = 0; i < DEPTH; i++) begin
            push(32'hA000_0000 + i);
            exp_q.push_back(32'hA000_0000 + i);
            peek(AD_STAT, v);
            case (i + 1)
                2:  check("R4 at ae thr", v[15:12], 32'hD);
                3:  check("R4 above ae thr", v[15:12], 32'hF);
                60: check("R4 below af level", v[15:12], 32'hF);
                61: check("R4 at af level", v[15:12], 32'hB);
                63: check("R3 one below full", v[15:12], 32'hB);
                64: check("R3 full", v[15:12], 32'h3);
                default: ;
            endcase
        end
        peek(AD_LVL, v); check("R11 level full", v, 32'(DEPTH));
        push(32'hBAD0_BAD0);
        peek(AD_LVL, v); check("R5 level held", v, 32'(DEPTH));
        peek(AD_STAT, v); check("R5 overrun set", v[23], 32'h1);
        wr(AD_STAT, 32'h0);
        peek(AD_STAT, v); check("R5 overrun sticky", v[23], 32'h1);
        wr(AD_STAT, 32'h0080_0000);
        peek(AD_STAT, v); check("R7 overrun cleared", v[23], 32'h0);
        push_pop(32'hC0DE_0001, v);
        check("R9 pair head", v, exp_q.pop_front());
        exp_q.push_back(32'hC0DE_0001);
        peek(AD_LVL, v); check("R9 pair level", v, 32'(DEPTH));
        peek(AD_STAT, v); check("R9 no overrun", v[23], 32'h0);
        for (int i = 0; i < DEPTH; i++) begin
            logic [31:0] e;
            pop(v); e = exp_q.pop_front();
            if (v !== e || i == DEPTH - 1) check("R5/R9 drain", v, e);
        end
        peek(AD_LVL, v); check("R5 drained", v, 32'h0);
    endtask

    task automatic t_underrun_w1c();
        logic [31:0] v;
        pop(v);
        peek(AD_LVL, v); check("R6 level 0", v, 32'h0);
        peek(AD_STAT, v); check("R6 underrun", v[22], 32'h1);
        wr(AD_STAT, 32'h0080_0000);
        peek(AD_STAT, v); check("R7 other bit kept", v[22], 32'h1);
        push(32'h5555_AAAA);
        peek(AD_STAT, v); check("R6 sticky", v[22], 32'h1);
        wr(AD_STAT, 32'h0040_0000);
        peek(AD_STAT, v); check("R7 underrun cleared", v[22], 32'h0);
        pop(v); check("R6 data after", v, 32'h5555_AAAA);
    endtask

    task automatic t_flush();
        logic [31:0] v;
        pop(v);
        for (int i = 0; i < 4; i++) push(32'h0F0F_0000 + i);
        wr(AD_CTRL, 32'h24);
        peek(AD_LVL, v); check("R8 flushed", v, 32'h0);
        peek(AD_CTRL, v); check("R8 self clear", v, 32'h20);
        peek(AD_STAT, v); check("R8 error kept", v[22], 32'h1);
        push(32'h7777_0001);
        pop(v); check("R8 usable after", v, 32'h7777_0001);
        wr(AD_STAT, 32'h00C0_0000);
    endtask

    task automatic t_board_reset();
        logic [31:0] v;
        for (int i = 0; i < 3; i++) push(32'h3333_0000 + i);
        wr(AD_THR, 32'h0005_0007);
        wr(AD_CTRL, 32'h21);
        peek(AD_LVL, v); check("R10 flushed", v, 32'h0);
        peek(AD_THR, v); check("R10 thr restored", v, 32'h0020_0020);
        peek(AD_CTRL, v); check("R10 ctrl restored", v, 32'h0);
        wr(AD_CTRL, 32'h20);
        push(32'h4444_0001);
        peek(AD_LVL, v); check("R10 push blocked", v, 32'h0);
        pop(v);
        peek(AD_STAT, v); check("R10 pop blocked", v[22], 32'h0);
        repeat (SETTLE + 5) @(posedge clk);
        push(32'h4444_0002);
        peek(AD_LVL, v); check("R10 accepts after", v, 32'h1);
        pop(v); check("R10 data after", v, 32'h4444_0002);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        t_reset();
        t_gate_order();
        t_levels_overrun();
        t_underrun_w1c();
        t_flush();
        t_board_reset();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++; n_err++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

endmodule